// File: doc/BRIEF.md
# Virtio legacy register window

This block is the legacy I/O register window of a virtio network function with three queues: receive, transmit and control. A host-side agent reaches it through a byte-addressed access port that carries an offset, an access size of 1, 2 or 4 bytes and, for writes, 16 bits of data. Behind the port sit a queue-select register, a clear-on-read interrupt status byte, a six-byte MAC address and one 16-bit interrupt vector index per queue. Ring processing lives elsewhere.

The layout follows the `msix_on` input from cycle to cycle. With message interrupts on, the window is 32 bytes and two vector registers sit at offsets 20 and 22, ahead of the device-specific area at 24. With them off, the vector registers are gone, the window is 28 bytes and every offset from 20 upward is moved up by four before decoding, so the MAC address starts at offset 20. When the receive or transmit engine raises `irq_req`, the block either emits that queue's stored vector index on `msg_vector` or, with message interrupts off, sets bit 0 of the status byte.

An access is handled by a two-state sequencer. In `ACC_IDLE`, `acc_ready` is high and an access is taken on the edge where `acc_valid` is high (transition IDLE to RESP). In `ACC_RESP`, read data is presented for one cycle and the sequencer always returns to `ACC_IDLE` (transition RESP to IDLE).

Top module: `vnet_regwin`

## Requirements
- R1: After reset all three vector entries hold 0xFFFF (no vector), the status byte and queue select are 0, `acc_ready` is 1 and neither `rd_valid` nor `msg_valid` is set.
- R2: With `msix_on` high, a 2-byte read or write at offset 20 reaches the control queue's vector, and offset 22 reaches the queue vector register. The MAC address starts at offset 24.
- R3: With `msix_on` low, an offset of 20 or more is raised by 4 before decoding. The vector registers cannot be reached, and the MAC address starts at offset 20.
- R4: The window is 32 bytes with `msix_on` high and 28 bytes with it low. An access whose offset plus size exceeds the window is ignored, as is any access whose size is not 1, 2 or 4. Any ignored read, and any read of an offset with no register, returns 0.
- R5: A vector register accepts only 2-byte accesses. Accesses of other sizes are ignored, and reads of other sizes return 0.
- R6: Queue select is a 2-byte register at offset 14 that holds 0 (receive), 1 (transmit) or 2 (control). Writes of a larger value are ignored. The queue vector register reads and writes the entry of the selected queue. While the control queue is selected, it reads 0 and ignores writes.
- R7: The status byte at offset 19 (1-byte read) returns its value and clears to 0. A set in the same cycle as the clearing read survives that read.
- R8: MAC octet i (parameter bits [8i+7:8i]) sits at decoded offset 24+i. Reads of 1, 2 or 4 bytes return the octets little-endian, provided the read ends within the six octets.
- R9: With `msix_on` high, `irq_req[0]` (receive) or `irq_req[1]` (transmit) produces `msg_valid` for one cycle in the next cycle, carrying that queue's stored vector. When both are requested together, receive is emitted first and transmit in the following cycle.
- R10: A request from a queue whose stored vector is 0xFFFF produces no message.
- R11: With `msix_on` low, a request produces no message and sets status bit 0.
- R12: An accepted access drops `acc_ready` for one cycle. A read raises `rd_valid` with its data in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msix_on | input | 1 | Message-interrupt mode enabled |
| acc_valid | input | 1 | Access request |
| acc_ready | output | 1 | Sequencer idle, access can be taken |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_off | input | ADDR_W | Byte offset into the window |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, little-endian |
| irq_req | input | 2 | Interrupt request: bit 0 receive, bit 1 transmit |
| msg_valid | output | 1 | Interrupt message valid |
| msg_vector | output | 16 | Vector index of the message |

## Verification
Read data is due in the cycle after the accepting edge, and a message is due in the cycle after the request edge. For simultaneous requests, the second message comes one cycle later still. Status and vector updates become visible to the next access. The driver applies stimulus on falling edges and pushes each expected read word or message into a queue before applying it. A monitor samples on every falling edge and pops one item for each `rd_valid` or `msg_valid` it sees, so an early, late, missing or extra result shows up as a mismatch or an unexpected item.

// File: rtl/vnet_pkg.sv
package vnet_pkg;
    typedef enum logic [2:0] {
        SEL_NONE, SEL_QSEL, SEL_ISR, SEL_CFGVEC, SEL_QVEC, SEL_MAC
    } reg_sel_e;

    typedef enum logic {ACC_IDLE, ACC_RESP} acc_state_e;

    localparam int unsigned NUM_Q    = 3;
    localparam int unsigned Q_RX     = 0;
    localparam int unsigned Q_TX     = 1;
    localparam int unsigned Q_CTL    = 2;
    localparam logic [15:0] NO_VECTOR = 16'hFFFF;

    localparam int unsigned OFF_QSEL   = 14;
    localparam int unsigned OFF_ISR    = 19;
    localparam int unsigned OFF_CFGVEC = 20;
    localparam int unsigned OFF_QVEC   = 22;
    localparam int unsigned OFF_SHIFT  = 20;
    localparam int unsigned SHIFT_AMT  = 4;
    localparam int unsigned MAC_BASE   = 24;
    localparam int unsigned MAC_LEN    = 6;
    localparam int unsigned WIN_MSIX   = 32;
    localparam int unsigned WIN_PLAIN  = 28;
endpackage

// File: rtl/vnet_decode.sv
module vnet_decode
    import vnet_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] raw_off,
    input  logic [2:0]        size,
    input  logic              msix_on,
    output logic              in_win,
    output reg_sel_e          sel,
    output logic [2:0]        mac_idx
);
    localparam int unsigned AW = ADDR_W + 1;

    logic [AW-1:0] raw_x, eff_x, end_raw, end_eff, win;
    logic          size_ok;

    always_comb begin
        raw_x   = {1'b0, raw_off};
        eff_x   = (!msix_on && raw_x >= AW'(OFF_SHIFT)) ? raw_x + AW'(SHIFT_AMT) : raw_x;
        end_raw = raw_x + AW'(size);
        end_eff = eff_x + AW'(size);
        win     = msix_on ? AW'(WIN_MSIX) : AW'(WIN_PLAIN);
        size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
        in_win  = size_ok && (end_raw <= win);
        mac_idx = 3'(eff_x - AW'(MAC_BASE));

        if (eff_x == AW'(OFF_QSEL) && size == 3'd2)
            sel = SEL_QSEL;
        else if (eff_x == AW'(OFF_ISR) && size == 3'd1)
            sel = SEL_ISR;
        else if (msix_on && eff_x == AW'(OFF_CFGVEC) && size == 3'd2)
            sel = SEL_CFGVEC;
        else if (msix_on && eff_x == AW'(OFF_QVEC) && size == 3'd2)
            sel = SEL_QVEC;
        else if (eff_x >= AW'(MAC_BASE) && end_eff <= AW'(MAC_BASE + MAC_LEN))
            sel = SEL_MAC;
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/vnet_vec_store.sv
module vnet_vec_store
    import vnet_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        msix_on,
    input  logic        wr_cfg,
    input  logic        wr_q,
    input  logic [1:0]  qsel,
    input  logic [15:0] wdata,
    input  logic [1:0]  irq_req,
    output logic [15:0] vec_ctl,
    output logic [15:0] vec_sel,
    output logic        msg_valid,
    output logic [15:0] msg_vector
);
    logic [15:0] vec_q [NUM_Q];
    logic [1:0]  pend_q, cand, pend_d;
    logic        emit;
    logic [15:0] emit_vec;

    for (genvar gi = 0; gi < NUM_Q; gi++) begin : g_vec
        logic we;
        if (gi == Q_CTL) begin : g_ctl
            assign we = wr_cfg;
        end else begin : g_data
            assign we = wr_q && (qsel == 2'(gi));
        end
        always_ff @(posedge clk) begin
            if (!rst_n)
                vec_q[gi] <= NO_VECTOR;
            else if (we)
                vec_q[gi] <= wdata;
        end
    end

    assign vec_ctl = vec_q[Q_CTL];
    assign vec_sel = (qsel == 2'(Q_RX)) ? vec_q[Q_RX] :
                     (qsel == 2'(Q_TX)) ? vec_q[Q_TX] : 16'h0000;

    // Lowest pending queue goes first; the rest waits a cycle.
    always_comb begin
        cand     = msix_on ? (pend_q | irq_req) : 2'b00;
        emit     = 1'b0;
        emit_vec = NO_VECTOR;
        pend_d   = cand;
        if (cand[Q_RX]) begin
            emit_vec     = vec_q[Q_RX];
            emit         = 1'b1;
            pend_d[Q_RX] = 1'b0;
        end else if (cand[Q_TX]) begin
            emit_vec     = vec_q[Q_TX];
            emit         = 1'b1;
            pend_d[Q_TX] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 2'b00;
            msg_valid  <= 1'b0;
            msg_vector <= NO_VECTOR;
        end else begin
            pend_q     <= pend_d;
            msg_valid  <= emit && (emit_vec != NO_VECTOR);
            msg_vector <= emit_vec;
        end
    end
endmodule

// File: rtl/vnet_isr.sv
module vnet_isr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_ev,
    input  logic       clr_rd,
    output logic [7:0] isr_q
);
    logic [7:0] isr_d;

    always_comb begin
        isr_d = clr_rd ? 8'h00 : isr_q;
        if (set_ev)
            isr_d[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            isr_q <= 8'h00;
        else
            isr_q <= isr_d;
    end
endmodule

// File: rtl/vnet_regwin.sv
module vnet_regwin
    import vnet_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [47:0] MAC_ADDR = 48'h665544332211
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msix_on,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_off,
    input  logic [2:0]        acc_size,
    input  logic [15:0]       acc_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic [1:0]        irq_req,
    output logic              msg_valid,
    output logic [15:0]       msg_vector
);
    acc_state_e  state_q, state_d;
    logic        fire, wr_hit, rd_hit;
    logic        in_win;
    reg_sel_e    sel;
    logic [2:0]  mac_idx;
    logic [1:0]  qsel_q;
    logic [7:0]  isr_q;
    logic [15:0] vec_ctl, vec_sel;
    logic [31:0] rdata;

    function automatic logic [7:0] mac_octet(input logic [2:0] i);
        unique case (i)
            3'd0:    mac_octet = MAC_ADDR[7:0];
            3'd1:    mac_octet = MAC_ADDR[15:8];
            3'd2:    mac_octet = MAC_ADDR[23:16];
            3'd3:    mac_octet = MAC_ADDR[31:24];
            3'd4:    mac_octet = MAC_ADDR[39:32];
            3'd5:    mac_octet = MAC_ADDR[47:40];
            default: mac_octet = 8'h00;
        endcase
    endfunction

    vnet_decode #(.ADDR_W(ADDR_W)) u_dec (
        .raw_off (acc_off),
        .size    (acc_size),
        .msix_on (msix_on),
        .in_win  (in_win),
        .sel     (sel),
        .mac_idx (mac_idx)
    );

    assign acc_ready = (state_q == ACC_IDLE);
    assign fire      = acc_valid && acc_ready;
    assign wr_hit    = fire && acc_write && in_win;
    assign rd_hit    = fire && !acc_write && in_win;

    vnet_vec_store u_vec (
        .clk        (clk),
        .rst_n      (rst_n),
        .msix_on    (msix_on),
        .wr_cfg     (wr_hit && sel == SEL_CFGVEC),
        .wr_q       (wr_hit && sel == SEL_QVEC),
        .qsel       (qsel_q),
        .wdata      (acc_wdata),
        .irq_req    (irq_req),
        .vec_ctl    (vec_ctl),
        .vec_sel    (vec_sel),
        .msg_valid  (msg_valid),
        .msg_vector (msg_vector)
    );

    vnet_isr u_isr (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (!msix_on && (irq_req != 2'b00)),
        .clr_rd (rd_hit && sel == SEL_ISR),
        .isr_q  (isr_q)
    );

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ACC_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ACC_IDLE: state_d = fire ? ACC_RESP : ACC_IDLE;
            ACC_RESP: state_d = ACC_IDLE;
        endcase
    end

    // Read data selection
    always_comb begin
        rdata = 32'h0;
        if (in_win) begin
            unique case (sel)
                SEL_QSEL:   rdata = {30'h0, qsel_q};
                SEL_ISR:    rdata = {24'h0, isr_q};
                SEL_CFGVEC: rdata = {16'h0, vec_ctl};
                SEL_QVEC:   rdata = {16'h0, vec_sel};
                SEL_MAC: begin
                    for (int k = 0; k < 4; k++)
                        if (3'(k) < acc_size)
                            rdata[8*k +: 8] = mac_octet(mac_idx + 3'(k));
                end
                default:    rdata = 32'h0;
            endcase
        end
    end

    // Outputs and queue select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 32'h0;
            qsel_q   <= 2'd0;
        end else begin
            rd_valid <= fire && !acc_write;
            if (fire && !acc_write)
                rd_data <= rdata;
            if (wr_hit && sel == SEL_QSEL && acc_wdata < 16'd3)
                qsel_q <= acc_wdata[1:0];
        end
    end
endmodule

// File: rtl/vnet_regwin_chk.sv
module vnet_regwin_chk #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msix_on,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_off,
    input logic [2:0]        acc_size,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              msg_valid,
    input logic [15:0]       msg_vector
);
    logic [ADDR_W:0] end_off;
    logic            oow_rd;

    assign end_off = {1'b0, acc_off} + (ADDR_W+1)'(acc_size);
    assign oow_rd  = acc_valid && acc_ready && !acc_write &&
                     (end_off > (msix_on ? (ADDR_W+1)'(32) : (ADDR_W+1)'(28)));

    p_rd_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_ready && !acc_write |=> rd_valid);

    p_ready_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_ready |=> !acc_ready);

    p_oow_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        oow_rd |=> rd_data == 32'h0);

    p_no_null_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_vector != 16'hFFFF);

    p_msg_needs_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $past(msix_on));
endmodule

bind vnet_regwin vnet_regwin_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msix_on    (msix_on),
    .acc_valid  (acc_valid),
    .acc_ready  (acc_ready),
    .acc_write  (acc_write),
    .acc_off    (acc_off),
    .acc_size   (acc_size),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .msg_valid  (msg_valid),
    .msg_vector (msg_vector)
);

// File: tb/vnet_regwin_tb_top.sv
module vnet_regwin_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msix_on = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_off = '0;
    logic [2:0]  acc_size = '0;
    logic [15:0] acc_wdata = '0;
    logic [1:0]  irq_req = '0;
    logic        acc_ready, rd_valid, msg_valid;
    logic [31:0] rd_data;
    logic [15:0] msg_vector;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] rd_exp_q[$];
    string       rd_tag_q[$];
    logic [15:0] msg_exp_q[$];
    string       msg_tag_q[$];

    always #5 clk = ~clk;

    vnet_regwin dut_i (
        .clk(clk), .rst_n(rst_n), .msix_on(msix_on),
        .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
        .acc_off(acc_off), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .irq_req(irq_req), .msg_valid(msg_valid), .msg_vector(msg_vector)
    );

    function automatic logic [7:0] mb(input int i);
        return 8'(17 * (i + 1));
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input int off, input int sz, input int wd,
                       input logic [31:0] exp, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_off = 8'(off);
        acc_size = 3'(sz); acc_wdata = 16'(wd);
        if (!wr) begin rd_exp_q.push_back(exp); rd_tag_q.push_back(tag); end
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic irq(input logic [1:0] r);
        @(negedge clk); irq_req = r;
        @(negedge clk); irq_req = 2'b00;
    endtask

    task automatic expect_msg(input logic [15:0] v, input string tag);
        msg_exp_q.push_back(v); msg_tag_q.push_back(tag);
    endtask

    // Monitor: pops one expected item per produced result
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rd_valid) begin
                if (rd_exp_q.size() == 0)
                    check(1'b0, "unexpected read", rd_data, 32'h0);
                else begin
                    automatic logic [31:0] e = rd_exp_q.pop_front();
                    automatic string t = rd_tag_q.pop_front();
                    check(rd_data === e, t, rd_data, e);
                end
            end
            if (msg_valid) begin
                if (msg_exp_q.size() == 0)
                    check(1'b0, "R10/R11 unexpected message", {16'h0, msg_vector}, 32'h0);
                else begin
                    automatic logic [15:0] e = msg_exp_q.pop_front();
                    automatic string t = msg_tag_q.pop_front();
                    check(msg_vector === e, t, {16'h0, msg_vector}, {16'h0, e});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(acc_ready === 1'b1, "R1 ready after reset", {31'h0, acc_ready}, 32'h1);
        check(rd_valid === 1'b0 && msg_valid === 1'b0, "R1 outputs idle", {30'h0, rd_valid, msg_valid}, 32'h0);
        acc(0, 20, 2, 0, 32'hFFFF, "R1 ctl vector reset");
        acc(0, 22, 2, 0, 32'hFFFF, "R1 rx vector reset");
        acc(0, 14, 2, 0, 32'h0, "R1 qsel reset");
        acc(0, 19, 1, 0, 32'h0, "R1 isr reset");

        // R2/R6 programming vectors
        acc(1, 22, 2, 5, 0, "");
        acc(1, 14, 2, 1, 0, "");
        acc(1, 22, 2, 7, 0, "");
        acc(1, 20, 2, 3, 0, "");
        acc(0, 22, 2, 0, 32'h7, "R6 tx vector via select");
        acc(1, 14, 2, 0, 0, "");
        acc(0, 22, 2, 0, 32'h5, "R6 rx vector via select");
        acc(0, 20, 2, 0, 32'h3, "R2 ctl vector at 20");
        // R6 control queue selected; bad select value ignored
        acc(1, 14, 2, 2, 0, "");
        acc(1, 22, 2, 16'h1234, 0, "");
        acc(0, 22, 2, 0, 32'h0, "R6 qvec reads 0 with ctl selected");
        acc(0, 20, 2, 0, 32'h3, "R6 ctl write via qvec ignored");
        acc(1, 14, 2, 3, 0, "");
        acc(0, 14, 2, 0, 32'h2, "R6 qsel value 3 ignored");
        acc(1, 14, 2, 0, 0, "");
        // R5 size checks
        acc(1, 20, 4, 16'h00AA, 0, "");
        acc(1, 20, 1, 16'h00BB, 0, "");
        acc(0, 20, 2, 0, 32'h3, "R5 non 2-byte vector writes ignored");
        acc(0, 20, 4, 0, 32'h0, "R5 4-byte vector read returns 0");

        // R9 messages
        expect_msg(16'h5, "R9 rx message");
        irq(2'b01);
        expect_msg(16'h7, "R9 tx message");
        irq(2'b10);
        expect_msg(16'h5, "R9 both: rx first");
        expect_msg(16'h7, "R9 both: tx second");
        irq(2'b11);
        repeat (2) @(negedge clk);
        // R10 null vector
        acc(1, 22, 2, 16'hFFFF, 0, "");
        irq(2'b01);
        expect_msg(16'h7, "R10 tx still delivered");
        irq(2'b10);
        repeat (2) @(negedge clk);

        // R8 MAC reads, MSI-X layout
        acc(0, 24, 4, 0, {mb(3), mb(2), mb(1), mb(0)}, "R8 mac 4-byte at 24");
        acc(0, 28, 2, 0, {16'h0, mb(5), mb(4)}, "R8 mac 2-byte at 28");
        acc(0, 25, 1, 0, {24'h0, mb(1)}, "R8 mac 1-byte at 25");
        acc(0, 26, 4, 0, {mb(5), mb(4), mb(3), mb(2)}, "R8 mac 4-byte at 26");
        // R4 window edges
        acc(0, 30, 2, 0, 32'h0, "R4 empty offset reads 0");
        acc(0, 30, 4, 0, 32'h0, "R4 past 32-byte window");
        acc(0, 24, 3, 0, 32'h0, "R4 size 3 ignored");

        // R3 plain layout
        @(negedge clk); msix_on = 1'b0;
        acc(0, 20, 4, 0, {mb(3), mb(2), mb(1), mb(0)}, "R3 mac at 20");
        acc(0, 24, 2, 0, {16'h0, mb(5), mb(4)}, "R3 mac tail at 24");
        acc(0, 26, 4, 0, 32'h0, "R4 past 28-byte window");
        acc(0, 28, 1, 0, 32'h0, "R4 offset 28 outside");
        acc(1, 20, 2, 16'h0044, 0, "");
        acc(0, 22, 2, 0, {16'h0, mb(3), mb(2)}, "R3 offset 22 is mac");

        // R11 / R7 status
        irq(2'b01);
        repeat (2) @(negedge clk);
        acc(0, 19, 1, 0, 32'h1, "R11 isr bit0 set");
        acc(0, 19, 1, 0, 32'h0, "R7 isr cleared by read");
        fork
            acc(0, 19, 1, 0, 32'h0, "R7 read during set");
            irq(2'b10);
        join
        acc(0, 19, 1, 0, 32'h1, "R7 same-cycle set survives");

        @(negedge clk); msix_on = 1'b1;
        acc(0, 20, 2, 0, 32'h3, "R3 vector kept through plain mode");
        repeat (4) @(negedge clk);
        check(rd_exp_q.size() == 0, "R12 all reads returned", rd_exp_q.size(), 0);
        check(msg_exp_q.size() == 0, "R9 all messages returned", msg_exp_q.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule